// File: doc/BRIEF.md
# Event-Gated Up-Counter with Dual Match Comparators

This block is a free-running up-counter whose advance is gated by a run bit. It compares its running value against two match registers, and a controller may rewrite either register at any time. Each comparator raises a one-cycle pulse on the first cycle that the count equals its register. A third pulse marks the first cycle that the count reads zero. Because the pulses are edge-qualified, a count that is frozen on a match value does not produce a repeated event.

An external trigger input can force a programmed value into the count, so the counter can be restarted from any value. A separate action-select bit decides whether the trigger acts at all. When a load and a run step both request the same cycle, the load takes effect. The count is held in a register that drives its output pin directly, so a reader always sees a settled value.

Top module: `evc_match_counter`

## Requirements
- R1: While `run_en` is 0 and no load is taken, `count_q` keeps its value across the clock edge.
- R2: While `run_en` is 1 and no load is taken, `count_q` rises by one on each edge. It wraps from all-ones to zero.
- R3: When `load_trig` and `load_act_en` are both 1 at an edge, `count_q` takes `load_val` after that edge, whatever `run_en` is.
- R4: When `load_act_en` is 0, `load_trig` has no effect, and the count follows `run_en` alone.
- R5: `hit1_pulse` is 1 in exactly those cycles where `count_q` equals match register 1 and did not equal it in the previous cycle.
- R6: `hit2_pulse` follows the same rule against match register 2, independently of `hit1_pulse`.
- R7: `zero_pulse` is 1 in exactly those cycles where `count_q` is zero and was nonzero in the previous cycle.
- R8: A write through `m1_we`/`m1_wdata` or `m2_we`/`m2_wdata` updates its register at that edge. A written value that equals a frozen count raises the pulse in the cycle after the write, and not in the write cycle.
- R9: A synchronous active-high `rst` clears the count and both match registers. In the cycles after reset, no pulse fires until an equality newly arises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Counting enable bit |
| load_trig | input | 1 | External trigger event |
| load_act_en | input | 1 | Selects load as the action taken on a trigger |
| load_val | input | CNT_W | Value loaded on a taken trigger |
| m1_we | input | 1 | Write strobe for match register 1 |
| m1_wdata | input | CNT_W | Write data for match register 1 |
| m2_we | input | 1 | Write strobe for match register 2 |
| m2_wdata | input | CNT_W | Write data for match register 2 |
| count_q | output | CNT_W | Current count |
| hit1_pulse | output | 1 | Match 1 event pulse |
| hit2_pulse | output | 1 | Match 2 event pulse |
| zero_pulse | output | 1 | Count-zero event pulse |

## Verification
A wrong count appears on `count_q` in the very cycle after the faulty edge. A skipped, doubled or missed load therefore shows within one clock. A corrupted match register or a stale previous-equality bit shows less directly: the pulse goes missing or arrives a cycle late, and may go unnoticed until the count next reaches that value. For this reason the stimulus walks the count through each match value, through zero and through the wrap point, holds it frozen on a match, and re-runs the comparisons after a reset to confirm that the registers were cleared.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } cnt_act_e;

  // Priority: a taken trigger beats a run step.
  function automatic cnt_act_e pick_act(input logic run, input logic trig, input logic act_en);
    if (trig && act_en) return ACT_LOAD;
    if (run)            return ACT_STEP;
    return ACT_HOLD;
  endfunction

  // First-cycle qualification of a level.
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl && !prev_lvl;
  endfunction

endpackage

// File: rtl/evc_rise_pulse.sv
module evc_rise_pulse (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic pulse
);
  logic prev_q;

  // Reset to 1: an equality present straight out of reset is not new.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level;
  end

  assign pulse = evc_pkg::rise_of(level, prev_q);
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_en,
  input  logic                  load_trig,
  input  logic                  load_act_en,
  input  logic [CNT_W-1:0]      load_val,
  output logic [CNT_W-1:0]      count_q,
  output evc_pkg::cnt_act_e     act_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + ONE;
  endfunction

  always_comb act_o = evc_pkg::pick_act(run_en, load_trig, load_act_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else begin
      unique case (act_o)
        evc_pkg::ACT_LOAD: count_q <= load_val;
        evc_pkg::ACT_STEP: count_q <= step(count_q);
        default:           count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/evc_match_slot.sv
module evc_match_slot #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] match_q,
  output logic             eq_o,
  output logic             hit_o
);
  always_ff @(posedge clk) begin
    if (rst)     match_q <= '0;
    else if (we) match_q <= wdata;
  end

  assign eq_o = (count_q == match_q);

  evc_rise_pulse u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (eq_o),
    .pulse (hit_o)
  );
endmodule

// File: rtl/evc_match_counter.sv
module evc_match_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             load_trig,
  input  logic             load_act_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             m1_we,
  input  logic [CNT_W-1:0] m1_wdata,
  input  logic             m2_we,
  input  logic [CNT_W-1:0] m2_wdata,
  output logic [CNT_W-1:0] count_q,
  output logic             hit1_pulse,
  output logic             hit2_pulse,
  output logic             zero_pulse
);
  localparam int NUM_SLOTS = 2;

  evc_pkg::cnt_act_e act_w;
  logic                 zero_lvl;
  logic [NUM_SLOTS-1:0] slot_we;
  logic [CNT_W-1:0]     slot_wdata [NUM_SLOTS];
  logic [CNT_W-1:0]     slot_match [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_eq;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic [CNT_W-1:0]     match1_q;
  logic [CNT_W-1:0]     match2_q;

  evc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .load_trig   (load_trig),
    .load_act_en (load_act_en),
    .load_val    (load_val),
    .count_q     (count_q),
    .act_o       (act_w)
  );

  assign slot_we       = {m2_we, m1_we};
  assign slot_wdata[0] = m1_wdata;
  assign slot_wdata[1] = m2_wdata;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    evc_match_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .we      (slot_we[i]),
      .wdata   (slot_wdata[i]),
      .count_q (count_q),
      .match_q (slot_match[i]),
      .eq_o    (slot_eq[i]),
      .hit_o   (slot_hit[i])
    );
  end

  assign match1_q   = slot_match[0];
  assign match2_q   = slot_match[1];
  assign hit1_pulse = slot_hit[0];
  assign hit2_pulse = slot_hit[1];

  assign zero_lvl = (count_q == '0);

  evc_rise_pulse u_zero (
    .clk   (clk),
    .rst   (rst),
    .level (zero_lvl),
    .pulse (zero_pulse)
  );
endmodule

// File: rtl/evc_counter_chk.sv
module evc_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run_en,
  input logic             load_trig,
  input logic             load_act_en,
  input logic [CNT_W-1:0] load_val,
  input logic             m1_we,
  input logic [CNT_W-1:0] m1_wdata,
  input logic             m2_we,
  input logic [CNT_W-1:0] m2_wdata,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] match1_q,
  input logic [CNT_W-1:0] match2_q,
  input logic             hit1_pulse,
  input logic             hit2_pulse,
  input logic             zero_pulse
);
  logic taken;
  assign taken = load_trig && load_act_en;

  p_freeze_r1: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !taken) |=> $stable(count_q));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run_en && !taken) |=> count_q == $past(count_q) + CNT_W'(1));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    taken |=> count_q == $past(load_val));

  p_hit_eq_r5: assert property (@(posedge clk) disable iff (rst)
    hit1_pulse |-> count_q == match1_q);

  p_hit_new_r5: assert property (@(posedge clk) disable iff (rst)
    ((count_q == match1_q) && !$past(count_q == match1_q)) |-> hit1_pulse);

  p_hit_once_r5: assert property (@(posedge clk) disable iff (rst)
    hit1_pulse |=> !hit1_pulse);

  p_hit_eq_r6: assert property (@(posedge clk) disable iff (rst)
    hit2_pulse |-> count_q == match2_q);

  p_hit_new_r6: assert property (@(posedge clk) disable iff (rst)
    ((count_q == match2_q) && !$past(count_q == match2_q)) |-> hit2_pulse);

  p_zero_eq_r7: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |-> count_q == '0);

  p_zero_once_r7: assert property (@(posedge clk) disable iff (rst)
    zero_pulse |=> !zero_pulse);

  p_wr1_r8: assert property (@(posedge clk) disable iff (rst)
    m1_we |=> match1_q == $past(m1_wdata));

  p_wr2_r8: assert property (@(posedge clk) disable iff (rst)
    m2_we |=> match2_q == $past(m2_wdata));

  p_clear_r9: assert property (@(posedge clk)
    rst |=> (count_q == '0) && (match1_q == '0) && (match2_q == '0));
endmodule

bind evc_match_counter evc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_en      (run_en),
  .load_trig   (load_trig),
  .load_act_en (load_act_en),
  .load_val    (load_val),
  .m1_we       (m1_we),
  .m1_wdata    (m1_wdata),
  .m2_we       (m2_we),
  .m2_wdata    (m2_wdata),
  .count_q     (count_q),
  .match1_q    (match1_q),
  .match2_q    (match2_q),
  .hit1_pulse  (hit1_pulse),
  .hit2_pulse  (hit2_pulse),
  .zero_pulse  (zero_pulse)
);

// File: tb/evc_match_counter_bench.sv
module evc_match_counter_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         run_en, load_trig, load_act_en;
  logic [W-1:0] load_val;
  logic         m1_we, m2_we;
  logic [W-1:0] m1_wdata, m2_wdata;
  logic [W-1:0] count_q;
  logic         hit1_pulse, hit2_pulse, zero_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  evc_match_counter #(.CNT_W(W)) u_evc_match_counter (
    .clk(clk), .rst(rst), .run_en(run_en), .load_trig(load_trig),
    .load_act_en(load_act_en), .load_val(load_val),
    .m1_we(m1_we), .m1_wdata(m1_wdata), .m2_we(m2_we), .m2_wdata(m2_wdata),
    .count_q(count_q), .hit1_pulse(hit1_pulse), .hit2_pulse(hit2_pulse),
    .zero_pulse(zero_pulse)
  );

  typedef struct packed {
    logic         run;
    logic         trig;
    logic         act;
    logic [W-1:0] lval;
    logic [W-1:0] cnt;
    logic         h1;
    logic         h2;
    logic         z;
  } vec_t;

  // Match 1 = 3, match 2 = 5 while this table runs; count starts at 0.
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'd1,          1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'd2,          1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'd3,          1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 32'd0,          32'd3,          1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 32'd100,        32'd4,          1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'd5,          1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b1, 32'd3,          32'd3,          1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 32'd0,          32'd0,          1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b1, 32'd0,          32'd1,          1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 32'hFFFF_FFFE,  32'hFFFF_FFFE,  1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'hFFFF_FFFF,  1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'd0,          1'b0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 32'd0,          32'd1,          1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 5000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; run_en = 1'b0; load_trig = 1'b0; load_act_en = 1'b0; load_val = '0;
    m1_we = 1'b0; m2_we = 1'b0; m1_wdata = '0; m2_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "count after reset", count_q, '0);
    chk("R9", "hit1 after reset", W'(hit1_pulse), '0);
    chk("R9", "hit2 after reset", W'(hit2_pulse), '0);
    chk("R9", "zero after reset", W'(zero_pulse), '0);

    // R8: load match registers while frozen at 0
    m1_we = 1'b1; m1_wdata = 32'd3; m2_we = 1'b1; m2_wdata = 32'd5;
    tick();
    m1_we = 1'b0; m2_we = 1'b0;
    chk("R8", "no hit after match write", W'(hit1_pulse | hit2_pulse), '0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      run_en = VECS[i].run; load_trig = VECS[i].trig;
      load_act_en = VECS[i].act; load_val = VECS[i].lval;
      tick();
      chk("R1/R2/R3/R4 vec", "count", count_q, VECS[i].cnt);
      chk("R5 vec", "hit1", W'(hit1_pulse), W'(VECS[i].h1));
      chk("R6 vec", "hit2", W'(hit2_pulse), W'(VECS[i].h2));
      chk("R7 vec", "zero", W'(zero_pulse), W'(VECS[i].z));
    end

    // R8: write match 2 equal to a frozen count of 1
    run_en = 1'b0; load_trig = 1'b0; load_act_en = 1'b0;
    m2_we = 1'b1; m2_wdata = 32'd1;
    #1;
    chk("R8", "hit2 in write cycle", W'(hit2_pulse), '0);
    tick();
    m2_we = 1'b0;
    chk("R8", "hit2 cycle after write", W'(hit2_pulse), 32'd1);
    chk("R1", "count frozen", count_q, 32'd1);
    tick();
    chk("R8", "hit2 not repeated", W'(hit2_pulse), '0);

    // R9: mid-run reset clears count and both match registers
    rst = 1'b1; run_en = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    chk("R9", "count cleared", count_q, '0);
    chk("R9", "no pulse after reset", W'(hit1_pulse | hit2_pulse | zero_pulse), '0);
    tick();
    chk("R9", "count runs", count_q, 32'd1);
    run_en = 1'b0; load_trig = 1'b1; load_act_en = 1'b1; load_val = '0;
    tick();
    load_trig = 1'b0;
    chk("R9", "match1 cleared to 0", W'(hit1_pulse), 32'd1);
    chk("R9", "match2 cleared to 0", W'(hit2_pulse), 32'd1);
    chk("R7", "zero on reload", W'(zero_pulse), 32'd1);

    finish_run();
  end
endmodule